// File: doc/BRIEF.md
# Peripheral Access Permission Checker

This block decides, for every bus request aimed at a protected peripheral, whether the request may proceed. It holds a small table of master identities that software programs through a simple write port. Each table row carries an ID, a compare mask, a read-only marker and a stored parity bit. The block checks the requester's ID against every row at once. It then applies the permission entry supplied for the addressed peripheral: a per-row enable vector, a secure marker and a parity bit. The address decoder and the bus protocol logic that supply these inputs sit outside the block.

The verdict appears one clock after the request. It consists of an allow bit, a poison bit and a six-bit error vector with at most one bit set. A row whose stored parity is wrong is taken out of matching. The aperture parity and master-ID miss conditions take precedence over the secure-world and permission checks, so the latter two are never reported alongside them. Requests to addresses that no aperture entry covers pass straight through.

Top module: `access_guard`

## Requirements
- R1: A table row matches a request only when the row is enabled, its stored parity is good (even parity over ID, mask, read-only bit and parity bit), and ((req_mid ^ id) & mask) == 0.
- R2: A row with bad parity never matches. When such a row would otherwise have matched, bit 5 of the error vector (master-ID parity, the lowest priority) is reported if no other error is present.
- R3: When no row matches a covered request, bit 1 (master-ID miss) is reported, allow is 0 and poison is 0.
- R4: On a covered write, bit 4 (read-only) is reported when any matched row that is enabled by the permission vector has its read-only bit set, even if other matched and enabled rows lack it. Poison is 1.
- R5: When the aperture entry has odd parity over its permission vector, secure bit and parity bit, bit 0 (aperture parity) is reported, allow is 0 and poison is 0.
- R6: A non-secure request to a peripheral marked secure reports bit 2 (secure-world violation) with poison 1.
- R7: Bit 3 (permission) is reported with poison 1 when no matched row is enabled by the permission vector, or when the burst-illegal input is set.
- R8: The error vector has at most one bit set, chosen by priority: bit 0, then 1, 2, 3, 4, 5. Secure-world and permission errors therefore never appear together with a miss or an aperture parity error.
- R9: A request whose address is not covered gives allow 1, poison 0 and an all-zero error vector, whatever the other inputs are.
- R10: Outputs are registered. The verdict appears on the clock edge after the request. Without a valid request, all outputs are 0 on the next edge.
- R11: After reset all rows are disabled. A table write takes effect for requests from the next cycle on. A write whose index is at or beyond the row count changes nothing.
- R12: Allow is 1 exactly when the request is valid and reports either no error or only bit 5. Allow and poison are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Table row write strobe |
| cfg_idx_i | input | IdxW | Row index to write |
| cfg_en_i | input | 1 | Row enable value |
| cfg_id_i | input | IdW | Row ID value |
| cfg_mask_i | input | IdW | Row compare mask |
| cfg_ro_i | input | 1 | Row read-only marker |
| cfg_par_i | input | 1 | Row stored parity bit |
| req_valid_i | input | 1 | Request present |
| req_mid_i | input | IdW | Requester master ID |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_nonsec_i | input | 1 | 1 for a non-secure request |
| req_burst_bad_i | input | 1 | Burst length/size illegal for a 32-byte buffer target |
| req_covered_i | input | 1 | Address falls under an aperture entry |
| ap_perm_i | input | NumEnt | Per-row enable vector of the aperture entry |
| ap_secure_i | input | 1 | Peripheral is secure-only |
| ap_par_i | input | 1 | Aperture entry parity bit |
| res_valid_o | output | 1 | Verdict valid |
| res_allow_o | output | 1 | Request may proceed |
| res_poison_o | output | 1 | Request must be poisoned |
| res_err_o | output | 6 | One-hot error: 0 aperture parity, 1 miss, 2 secure, 3 permission, 4 read-only, 5 ID parity |

## Verification
The bench builds the block with six table rows and eight-bit IDs. With six rows the three-bit index can name rows 6 and 7, so writes past the table end can actually be issued and shown to have no effect. Eight-bit IDs leave room to use masks that cover only the upper nibble. With these settings a single request can match several rows at once: a read-only row together with a writable one, or a good row together with a bad-parity one. That makes the priority ordering between the read-only, parity and secure-world errors observable at the ports.

// File: rtl/access_guard_pkg.sv
package access_guard_pkg;
  localparam int unsigned NumErr    = 6;
  localparam int unsigned ErrApPar  = 0;
  localparam int unsigned ErrMiss   = 1;
  localparam int unsigned ErrSec    = 2;
  localparam int unsigned ErrPerm   = 3;
  localparam int unsigned ErrRo     = 4;
  localparam int unsigned ErrMidPar = 5;

  typedef logic [NumErr-1:0] err_vec_t;

  // errors that block the request
  localparam err_vec_t BlockMask  = err_vec_t'(6'b011111);
  // errors that poison rather than drop
  localparam err_vec_t PoisonMask = err_vec_t'(6'b011100);
endpackage

// File: rtl/access_guard_mid_table.sv
module access_guard_mid_table #(
  parameter int unsigned NumEnt = 20,
  parameter int unsigned IdW    = 10,
  parameter int unsigned IdxW   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [IdxW-1:0]   cfg_idx_i,
  input  logic              cfg_en_i,
  input  logic [IdW-1:0]    cfg_id_i,
  input  logic [IdW-1:0]    cfg_mask_i,
  input  logic              cfg_ro_i,
  input  logic              cfg_par_i,
  input  logic [IdW-1:0]    req_mid_i,
  output logic [NumEnt-1:0] match_o,
  output logic [NumEnt-1:0] bad_hit_o,
  output logic [NumEnt-1:0] ro_o
);
  typedef struct packed {
    logic           en;
    logic [IdW-1:0] id;
    logic [IdW-1:0] mask;
    logic           ro;
    logic           par;
  } row_t;

  row_t row_q [NumEnt];

  for (genvar g = 0; g < NumEnt; g++) begin : g_row
    logic wr_sel;
    logic raw_hit;
    logic par_ok;

    assign wr_sel = cfg_we_i && (cfg_idx_i == IdxW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        row_q[g] <= '0;
      end else if (wr_sel) begin
        row_q[g] <= '{en: cfg_en_i, id: cfg_id_i, mask: cfg_mask_i,
                      ro: cfg_ro_i, par: cfg_par_i};
      end
    end

    assign raw_hit      = row_q[g].en &&
                          ~|((req_mid_i ^ row_q[g].id) & row_q[g].mask);
    assign par_ok       = ~^{row_q[g].id, row_q[g].mask, row_q[g].ro, row_q[g].par};
    assign match_o[g]   = raw_hit & par_ok;
    assign bad_hit_o[g] = raw_hit & ~par_ok;
    assign ro_o[g]      = row_q[g].ro;

    // R11: row untouched unless its own index is written
    a_r11_row_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(cfg_we_i && (cfg_idx_i == IdxW'(g))) |=> $stable(row_q[g]));

    // R2: bad-parity row never reported as match
    a_r2_bad_excluded: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bad_hit_o[g] |-> !match_o[g]);
  end
endmodule

// File: rtl/access_guard_aperture_chk.sv
module access_guard_aperture_chk #(
  parameter int unsigned NumEnt = 20
) (
  input  logic [NumEnt-1:0] ap_perm_i,
  input  logic              ap_secure_i,
  input  logic              ap_par_i,
  input  logic              req_nonsec_i,
  input  logic [NumEnt-1:0] match_i,
  input  logic [NumEnt-1:0] ro_i,
  output logic              ap_bad_o,
  output logic              sec_viol_o,
  output logic              no_grant_o,
  output logic              ro_grant_o
);
  logic [NumEnt-1:0] granted;

  assign granted    = match_i & ap_perm_i;
  assign ap_bad_o   = ^{ap_perm_i, ap_secure_i, ap_par_i};
  assign sec_viol_o = req_nonsec_i & ap_secure_i;
  assign no_grant_o = ~|granted;
  // any read-only grant wins over writable ones
  assign ro_grant_o = |(granted & ro_i);
endmodule

// File: rtl/access_guard_arbiter.sv
module access_guard_arbiter
  import access_guard_pkg::*;
(
  input  err_vec_t raw_i,
  output err_vec_t win_o,
  output logic     allow_o,
  output logic     poison_o
);
  always_comb begin
    win_o = '0;
    for (int unsigned i = 0; i < NumErr; i++) begin
      if (raw_i[i] && (win_o == '0)) win_o[i] = 1'b1;
    end
  end

  assign allow_o  = ~|(win_o & BlockMask);
  assign poison_o = |(win_o & PoisonMask);
endmodule

// File: rtl/access_guard.sv
module access_guard
  import access_guard_pkg::*;
#(
  parameter int unsigned NumEnt = 20,
  parameter int unsigned IdW    = 10,
  parameter int unsigned IdxW   = (NumEnt > 1) ? $clog2(NumEnt) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [IdxW-1:0]   cfg_idx_i,
  input  logic              cfg_en_i,
  input  logic [IdW-1:0]    cfg_id_i,
  input  logic [IdW-1:0]    cfg_mask_i,
  input  logic              cfg_ro_i,
  input  logic              cfg_par_i,
  input  logic              req_valid_i,
  input  logic [IdW-1:0]    req_mid_i,
  input  logic              req_write_i,
  input  logic              req_nonsec_i,
  input  logic              req_burst_bad_i,
  input  logic              req_covered_i,
  input  logic [NumEnt-1:0] ap_perm_i,
  input  logic              ap_secure_i,
  input  logic              ap_par_i,
  output logic              res_valid_o,
  output logic              res_allow_o,
  output logic              res_poison_o,
  output logic [NumErr-1:0] res_err_o
);
  logic [NumEnt-1:0] match, bad_hit, row_ro;
  logic ap_bad, sec_viol, no_grant, ro_grant;
  err_vec_t raw_err, win_err;
  logic win_allow, win_poison;

  access_guard_mid_table #(.NumEnt(NumEnt), .IdW(IdW), .IdxW(IdxW)) i_table (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_idx_i, .cfg_en_i, .cfg_id_i,
    .cfg_mask_i, .cfg_ro_i, .cfg_par_i, .req_mid_i,
    .match_o(match), .bad_hit_o(bad_hit), .ro_o(row_ro)
  );

  access_guard_aperture_chk #(.NumEnt(NumEnt)) i_aper (
    .ap_perm_i, .ap_secure_i, .ap_par_i, .req_nonsec_i,
    .match_i(match), .ro_i(row_ro),
    .ap_bad_o(ap_bad), .sec_viol_o(sec_viol),
    .no_grant_o(no_grant), .ro_grant_o(ro_grant)
  );

  // uncovered addresses are not checked at all
  always_comb begin
    raw_err            = '0;
    raw_err[ErrApPar]  = req_covered_i & ap_bad;
    raw_err[ErrMiss]   = req_covered_i & ~|match;
    raw_err[ErrSec]    = req_covered_i & sec_viol;
    raw_err[ErrPerm]   = req_covered_i & (no_grant | req_burst_bad_i);
    raw_err[ErrRo]     = req_covered_i & req_write_i & ro_grant;
    raw_err[ErrMidPar] = req_covered_i & |bad_hit;
  end

  access_guard_arbiter i_arb (
    .raw_i(raw_err), .win_o(win_err), .allow_o(win_allow), .poison_o(win_poison)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o  <= 1'b0;
      res_allow_o  <= 1'b0;
      res_poison_o <= 1'b0;
      res_err_o    <= '0;
    end else begin
      res_valid_o  <= req_valid_i;
      res_allow_o  <= req_valid_i & win_allow;
      res_poison_o <= req_valid_i & win_poison;
      res_err_o    <= req_valid_i ? win_err : '0;
    end
  end

  // R10
  a_r10_idle_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !res_valid_o && !res_allow_o && !res_poison_o && (res_err_o == '0));

  // R9
  a_r9_uncovered_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_covered_i |=> res_allow_o && !res_poison_o && (res_err_o == '0));

  // R8
  a_r8_miss_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_covered_i && (match == '0)
    |=> !res_err_o[ErrSec] && !res_err_o[ErrPerm]);

  // R5
  a_r5_aper_parity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_covered_i && ap_bad |=> res_err_o[ErrApPar] && !res_allow_o);

  // R8
  a_r8_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(res_err_o));

  // R12
  a_r12_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(res_allow_o && res_poison_o));
endmodule

// File: tb/test_access_guard.sv
`timescale 1ns/1ps
module test_access_guard;
  localparam int unsigned NE = 6;
  localparam int unsigned IW = 8;
  localparam int unsigned XW = 3;

  localparam logic [5:0] E_NONE = 6'b000000;
  localparam logic [5:0] E_AP   = 6'b000001;
  localparam logic [5:0] E_MISS = 6'b000010;
  localparam logic [5:0] E_SEC  = 6'b000100;
  localparam logic [5:0] E_PERM = 6'b001000;
  localparam logic [5:0] E_RO   = 6'b010000;
  localparam logic [5:0] E_MPAR = 6'b100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_en = 1'b0, cfg_ro = 1'b0, cfg_par = 1'b0;
  logic [XW-1:0] cfg_idx = '0;
  logic [IW-1:0] cfg_id = '0, cfg_mask = '0;
  logic req_valid = 1'b0, req_write = 1'b0, req_nonsec = 1'b0;
  logic req_burst_bad = 1'b0, req_covered = 1'b0;
  logic [IW-1:0] req_mid = '0;
  logic [NE-1:0] ap_perm = '0;
  logic ap_secure = 1'b0, ap_par = 1'b0;
  logic res_valid, res_allow, res_poison;
  logic [5:0] res_err;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  access_guard #(.NumEnt(NE), .IdW(IW)) i_access_guard (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_en_i(cfg_en),
    .cfg_id_i(cfg_id), .cfg_mask_i(cfg_mask), .cfg_ro_i(cfg_ro), .cfg_par_i(cfg_par),
    .req_valid_i(req_valid), .req_mid_i(req_mid), .req_write_i(req_write),
    .req_nonsec_i(req_nonsec), .req_burst_bad_i(req_burst_bad),
    .req_covered_i(req_covered), .ap_perm_i(ap_perm), .ap_secure_i(ap_secure),
    .ap_par_i(ap_par),
    .res_valid_o(res_valid), .res_allow_o(res_allow),
    .res_poison_o(res_poison), .res_err_o(res_err)
  );

  task automatic check(string req, logic v, logic a, logic p, logic [5:0] e);
    total++;
    if (res_valid !== v || res_allow !== a || res_poison !== p || res_err !== e) begin
      bad++;
      $display("FAIL %s: got v=%b a=%b p=%b err=%b, exp v=%b a=%b p=%b err=%b",
               req, res_valid, res_allow, res_poison, res_err, v, a, p, e);
    end
  endtask

  task automatic write_row(int idx, logic en, logic [IW-1:0] id, logic [IW-1:0] mask,
                           logic ro, logic corrupt);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = XW'(idx); cfg_en = en; cfg_id = id;
    cfg_mask = mask; cfg_ro = ro; cfg_par = (^{id, mask, ro}) ^ corrupt;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic send(logic [IW-1:0] mid, logic wr, logic ns, logic bb, logic cov,
                      logic [NE-1:0] perm, logic sec, logic ap_corrupt);
    @(negedge clk);
    req_valid = 1'b1; req_mid = mid; req_write = wr; req_nonsec = ns;
    req_burst_bad = bb; req_covered = cov; ap_perm = perm; ap_secure = sec;
    ap_par = (^{perm, sec}) ^ ap_corrupt;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    check("R10 reset", 1'b0, 1'b0, 1'b0, E_NONE);
    send(8'h12, 1'b0, 1'b0, 1'b0, 1'b1, 6'b111111, 1'b0, 1'b0);
    check("R11 rows disabled after reset", 1'b1, 1'b0, 1'b0, E_MISS);
  endtask

  task automatic t_uncovered();
    send(8'h77, 1'b1, 1'b1, 1'b1, 1'b0, 6'b000000, 1'b1, 1'b1);
    check("R9 uncovered passes", 1'b1, 1'b1, 1'b0, E_NONE);
  endtask

  task automatic t_program();
    write_row(0, 1'b1, 8'h12, 8'hFF, 1'b0, 1'b0);
    write_row(1, 1'b1, 8'h30, 8'hF0, 1'b1, 1'b0);
    write_row(2, 1'b1, 8'h55, 8'hFF, 1'b0, 1'b1);
    write_row(3, 1'b1, 8'h35, 8'hFF, 1'b0, 1'b0);
  endtask

  task automatic t_match_allow();
    send(8'h12, 1'b0, 1'b0, 1'b0, 1'b1, 6'b000001, 1'b0, 1'b0);
    check("R1 exact match allowed", 1'b1, 1'b1, 1'b0, E_NONE);
    send(8'h13, 1'b0, 1'b0, 1'b0, 1'b1, 6'b000001, 1'b0, 1'b0);
    check("R3 one-bit ID difference misses", 1'b1, 1'b0, 1'b0, E_MISS);
  endtask

  task automatic t_perm();
    send(8'h12, 1'b0, 1'b0, 1'b0, 1'b1, 6'b000010, 1'b0, 1'b0);
    check("R7 no enabled row", 1'b1, 1'b0, 1'b1, E_PERM);
    send(8'h12, 1'b0, 1'b0, 1'b1, 1'b1, 6'b000001, 1'b0, 1'b0);
    check("R7 illegal burst", 1'b1, 1'b0, 1'b1, E_PERM);
  endtask

  task automatic t_secure();
    send(8'h12, 1'b0, 1'b1, 1'b0, 1'b1, 6'b000001, 1'b1, 1'b0);
    check("R6 non-secure to secure", 1'b1, 1'b0, 1'b1, E_SEC);
    send(8'h12, 1'b0, 1'b0, 1'b0, 1'b1, 6'b000001, 1'b1, 1'b0);
    check("R6 secure to secure allowed", 1'b1, 1'b1, 1'b0, E_NONE);
    send(8'h77, 1'b0, 1'b1, 1'b1, 1'b1, 6'b000001, 1'b1, 1'b0);
    check("R8 miss masks secure and perm", 1'b1, 1'b0, 1'b0, E_MISS);
  endtask

  task automatic t_aper_parity();
    send(8'h12, 1'b0, 1'b0, 1'b0, 1'b1, 6'b000001, 1'b0, 1'b1);
    check("R5 aperture parity", 1'b1, 1'b0, 1'b0, E_AP);
    send(8'h77, 1'b0, 1'b1, 1'b0, 1'b1, 6'b000001, 1'b1, 1'b1);
    check("R8 aperture parity over miss", 1'b1, 1'b0, 1'b0, E_AP);
  endtask

  task automatic t_read_only();
    send(8'h35, 1'b1, 1'b0, 1'b0, 1'b1, 6'b000010, 1'b0, 1'b0);
    check("R4 write to read-only row", 1'b1, 1'b0, 1'b1, E_RO);
    send(8'h35, 1'b0, 1'b0, 1'b0, 1'b1, 6'b000010, 1'b0, 1'b0);
    check("R4 read through read-only row", 1'b1, 1'b1, 1'b0, E_NONE);
    send(8'h35, 1'b1, 1'b0, 1'b0, 1'b1, 6'b001010, 1'b0, 1'b0);
    check("R4 mixed read-only and writable", 1'b1, 1'b0, 1'b1, E_RO);
    send(8'h35, 1'b1, 1'b0, 1'b0, 1'b1, 6'b001000, 1'b0, 1'b0);
    check("R4 writable row only enabled", 1'b1, 1'b1, 1'b0, E_NONE);
  endtask

  task automatic t_mid_parity();
    send(8'h55, 1'b0, 1'b0, 1'b0, 1'b1, 6'b111111, 1'b0, 1'b0);
    check("R2 bad-parity row removed", 1'b1, 1'b0, 1'b0, E_MISS);
    write_row(4, 1'b1, 8'h50, 8'hF0, 1'b0, 1'b0);
    send(8'h55, 1'b0, 1'b0, 1'b0, 1'b1, 6'b010000, 1'b0, 1'b0);
    check("R2 parity flag with good match", 1'b1, 1'b1, 1'b0, E_MPAR);
    send(8'h55, 1'b0, 1'b1, 1'b0, 1'b1, 6'b010000, 1'b1, 1'b0);
    check("R8 secure error over ID parity", 1'b1, 1'b0, 1'b1, E_SEC);
  endtask

  task automatic t_out_of_range();
    write_row(6, 1'b1, 8'h77, 8'hFF, 1'b0, 1'b0);
    write_row(7, 1'b1, 8'h77, 8'hFF, 1'b0, 1'b0);
    send(8'h77, 1'b0, 1'b0, 1'b0, 1'b1, 6'b111111, 1'b0, 1'b0);
    check("R11 out-of-range write ignored", 1'b1, 1'b0, 1'b0, E_MISS);
    send(8'h12, 1'b0, 1'b0, 1'b0, 1'b1, 6'b000001, 1'b0, 1'b0);
    check("R11 row 0 intact", 1'b1, 1'b1, 1'b0, E_NONE);
  endtask

  task automatic t_idle();
    idle();
    check("R10 no request clears outputs", 1'b0, 1'b0, 1'b0, E_NONE);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset_pre: begin end
    check("R10 in reset", 1'b0, 1'b0, 1'b0, E_NONE);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_uncovered();
    t_program();
    t_match_allow();
    t_perm();
    t_secure();
    t_aper_parity();
    t_read_only();
    t_mid_parity();
    t_out_of_range();
    t_idle();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog R10: got no completion, exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule